// File: doc/BRIEF.md
# Two-Slot Move Command Queue

This block sits in front of one channel's step generator and buffers the moves that the host has issued but the generator has not yet started. Move lengths (24-bit counts) and move configurations (28-bit control words) go into two separate two-entry queues. A count write is what schedules a move. A control word only has to be written when the configuration changes. When the generator reports that its counter has reached zero and a count is waiting, the queue hands over the head count together with a control word in the same cycle. If no new control word is waiting, the configuration of the previous move is used again. Back-to-back moves therefore run with no idle gap between them.

The block also produces the channel status lines: room left, data waiting, queue drained, move finished and channel idle. It keeps two sticky event flags, one for each load and one for each finished move. Each flag has its own detector enable, its own interrupt enable and a write-one-to-clear input. A queue reset empties both queues and forgets the remembered configuration.

Top module: `move_queue`

## Requirements
- R1: After reset, with the generator reporting zero, queue_empty=1, data_ready=0, slots_avail=1, move_done=1, chan_idle=1, load_stb=0, and both event flags and both interrupt requests are 0.
- R2: The count queue holds two entries. slots_avail is 0 exactly while two counts are held. A count write made while two counts are held (judged before any load in that cycle) is discarded.
- R3: In any cycle where gen_zero=1, a count is held and queue_rst=0, load_stb is 1 and load_count shows the oldest held count. That count is removed at the clock edge. Counts leave in the order they were written.
- R4: On a load, load_ctl shows the oldest queued control word, which is removed along with the count. If no control word is queued, load_ctl shows the control word applied at the previous load, which is 0 after reset.
- R5: The control queue holds two entries. A control write made while two words are held (judged before any load in that cycle) is discarded.
- R6: queue_empty is 1 exactly when no count is held, and data_ready is its inverse.
- R7: move_done = gen_zero AND no count held. chan_idle = move_done AND queue_empty.
- R8: load_occur is set at the clock edge of each load while load_det_en=1. It is cleared by load_occ_clr=1. A set in the same cycle as a clear wins.
- R9: done_occur is set at the edge following a cycle in which move_done is 1 after having been 0 in the previous cycle, with done_det_en=1. It is cleared by done_occ_clr=1, and a set wins over a clear. The move_done level present out of reset is not an event.
- R10: load_irq = load_occur AND load_irq_en, and done_irq = done_occur AND done_irq_en.
- R11: queue_rst=1 empties both queues, resets the remembered control word to 0 and suppresses any load in that cycle. It leaves both event flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| queue_rst | input | 1 | Synchronous queue and configuration clear |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 24 | Count to enqueue |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 28 | Control word to enqueue |
| gen_zero | input | 1 | Generator counter is at zero |
| load_det_en | input | 1 | Load event detector enable |
| load_irq_en | input | 1 | Load event interrupt enable |
| load_occ_clr | input | 1 | Write-one clear of the load event flag |
| done_det_en | input | 1 | Move-finished detector enable |
| done_irq_en | input | 1 | Move-finished interrupt enable |
| done_occ_clr | input | 1 | Write-one clear of the move-finished flag |
| load_stb | output | 1 | Generator loads count and control this cycle |
| load_count | output | 24 | Count handed to the generator |
| load_ctl | output | 28 | Control word handed to the generator |
| slots_avail | output | 1 | Count queue has room |
| data_ready | output | 1 | A count waits at the queue head |
| queue_empty | output | 1 | No count held |
| move_done | output | 1 | Generator at zero and nothing queued |
| chan_idle | output | 1 | Channel idle |
| load_occur | output | 1 | Sticky load event flag |
| done_occur | output | 1 | Sticky move-finished flag |
| load_irq | output | 1 | Load interrupt request |
| done_irq | output | 1 | Move-finished interrupt request |

## Verification
The bench drives writes into full queues in the same cycle as a load. A design that tested fullness after the pop would accept a third count or control word that should have been discarded. It also drains the control queue before the count queue. A design that lost the remembered configuration, or that took a stale head entry, would give the generator a wrong control word. Flag clears are made to coincide with new events, and a queue reset is issued with entries pending. These cases expose set/clear priority mistakes, flags that are wrongly wiped by the reset, and a configuration memory that survives the reset when it should not. Coming out of reset, the bench watches for a move-finished event. A missing initial edge history would produce a spurious event there.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int CNT_W = 24;
  localparam int CTL_W = 28;
  localparam int QDEPTH = 2;

  // circular pointer advance
  function automatic int ptr_next(input int p, input int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy after one edge of accepted push / pop
  function automatic int level_next(input int lvl, input bit push_ok, input bit pop_ok);
    return lvl + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
  endfunction
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LW-1:0]    level;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= PW'(mq_pkg::ptr_next(int'(wp), DEPTH));
      if (pop_ok)  rp <= PW'(mq_pkg::ptr_next(int'(rp), DEPTH));
      level <= LW'(mq_pkg::level_next(int'(level), push_ok, pop_ok));
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  // R2 / R5: occupancy never exceeds the depth
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2 / R5: a write into a full queue with no pop leaves it full
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);

  // R11: a clear leaves the queue empty
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/mq_occur.sv
module mq_occur (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  input  logic det_en,
  input  logic irq_en,
  input  logic clr,
  output logic occur,
  output logic irq
);
  logic set_now;
  assign set_now = event_in && det_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       occur <= 1'b0;
    else if (set_now) occur <= 1'b1;
    else if (clr)     occur <= 1'b0;
  end

  assign irq = occur && irq_en;

  // R8 / R9: a flag only rises after an enabled event
  assert_rise_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(occur) |-> $past(event_in && det_en));

  // R8 / R9: an enabled event always leaves the flag set
  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> occur);

  // R10: no request without a flag
  assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> occur);
endmodule

// File: rtl/move_queue.sv
module move_queue #(
  parameter int CNT_W = mq_pkg::CNT_W,
  parameter int CTL_W = mq_pkg::CTL_W,
  parameter int DEPTH = mq_pkg::QDEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queue_rst,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             gen_zero,
  input  logic             load_det_en,
  input  logic             load_irq_en,
  input  logic             load_occ_clr,
  input  logic             done_det_en,
  input  logic             done_irq_en,
  input  logic             done_occ_clr,
  output logic             load_stb,
  output logic [CNT_W-1:0] load_count,
  output logic [CTL_W-1:0] load_ctl,
  output logic             slots_avail,
  output logic             data_ready,
  output logic             queue_empty,
  output logic             move_done,
  output logic             chan_idle,
  output logic             load_occur,
  output logic             done_occur,
  output logic             load_irq,
  output logic             done_irq
);
  // named internal events
  logic             cnt_full, cnt_empty, cnt_push_ok, cnt_pop_ok;
  logic             ctl_full, ctl_empty, ctl_push_ok, ctl_pop_ok;
  logic [CTL_W-1:0] ctl_head;
  logic [CTL_W-1:0] last_ctl;
  logic             done_prev;
  logic             done_rise;

  assign load_stb = gen_zero && !cnt_empty && !queue_rst;

  mq_fifo #(.WIDTH(CNT_W), .DEPTH(DEPTH)) u_cnt_q (
    .clk(clk), .rst_n(rst_n), .clr(queue_rst),
    .push(cnt_wr), .push_data(cnt_wdata), .pop(load_stb),
    .head(load_count), .full(cnt_full), .empty(cnt_empty),
    .push_ok(cnt_push_ok), .pop_ok(cnt_pop_ok)
  );

  mq_fifo #(.WIDTH(CTL_W), .DEPTH(DEPTH)) u_ctl_q (
    .clk(clk), .rst_n(rst_n), .clr(queue_rst),
    .push(ctl_wr), .push_data(ctl_wdata), .pop(load_stb),
    .head(ctl_head), .full(ctl_full), .empty(ctl_empty),
    .push_ok(ctl_push_ok), .pop_ok(ctl_pop_ok)
  );

  assign load_ctl = ctl_empty ? last_ctl : ctl_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_ctl <= '0;
    else if (queue_rst) last_ctl <= '0;
    else if (load_stb)  last_ctl <= load_ctl;
  end

  assign slots_avail = !cnt_full;
  assign queue_empty = cnt_empty;
  assign data_ready  = !cnt_empty;
  assign move_done   = gen_zero && cnt_empty;
  assign chan_idle   = move_done && queue_empty;

  // edge history starts high so the level at reset is not an event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_prev <= 1'b1;
    else        done_prev <= move_done;
  end
  assign done_rise = move_done && !done_prev;

  mq_occur u_load_flag (
    .clk(clk), .rst_n(rst_n), .event_in(load_stb), .det_en(load_det_en),
    .irq_en(load_irq_en), .clr(load_occ_clr), .occur(load_occur), .irq(load_irq)
  );

  mq_occur u_done_flag (
    .clk(clk), .rst_n(rst_n), .event_in(done_rise), .det_en(done_det_en),
    .irq_en(done_irq_en), .clr(done_occ_clr), .occur(done_occur), .irq(done_irq)
  );

  // R3: every load pops exactly one count
  assert_load_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> cnt_pop_ok);

  // R4: the word handed over becomes the remembered configuration
  assert_ctl_retained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !queue_rst) |=> last_ctl == $past(load_ctl));

  // R4: a control word leaves only alongside a count
  assert_ctl_with_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pop_ok |-> cnt_pop_ok);

  // R7: a finished move never coincides with a load
  assert_done_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    move_done |-> !load_stb);

  // R11: after a queue reset nothing is held and the configuration is cleared
  assert_qrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    queue_rst |=> (queue_empty && ctl_empty && last_ctl == '0));
endmodule

// File: tb/move_queue_tb_top.sv
module move_queue_tb_top;
  localparam int CW = 24;
  localparam int KW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic queue_rst = 0, cnt_wr = 0, ctl_wr = 0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [KW-1:0] ctl_wdata = '0;
  logic load_det_en = 0, load_irq_en = 0, load_occ_clr = 0;
  logic done_det_en = 0, done_irq_en = 0, done_occ_clr = 0;
  logic gen_hold = 0;
  int   gen_cnt = 0;
  logic gen_zero;

  logic load_stb, slots_avail, data_ready, queue_empty, move_done, chan_idle;
  logic load_occur, done_occur, load_irq, done_irq;
  logic [CW-1:0] load_count;
  logic [KW-1:0] load_ctl;

  always #5 clk = ~clk;
  assign gen_zero = (gen_cnt == 0);

  move_queue dut_i (
    .clk(clk), .rst_n(rst_n), .queue_rst(queue_rst),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .gen_zero(gen_zero), .load_det_en(load_det_en), .load_irq_en(load_irq_en),
    .load_occ_clr(load_occ_clr), .done_det_en(done_det_en), .done_irq_en(done_irq_en),
    .done_occ_clr(done_occ_clr), .load_stb(load_stb), .load_count(load_count),
    .load_ctl(load_ctl), .slots_avail(slots_avail), .data_ready(data_ready),
    .queue_empty(queue_empty), .move_done(move_done), .chan_idle(chan_idle),
    .load_occur(load_occur), .done_occur(done_occur), .load_irq(load_irq),
    .done_irq(done_irq)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [CW-1:0] mq_cnt[$];
  logic [KW-1:0] mq_ctl[$];
  logic [KW-1:0] m_last = '0;
  bit m_lflag = 0, m_dflag = 0, m_dprev = 1;

  function automatic bit m_load();
    return gen_zero && mq_cnt.size() > 0 && !queue_rst;
  endfunction
  function automatic bit m_done();
    return gen_zero && mq_cnt.size() == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_cnt.delete(); mq_ctl.delete();
      m_last = '0; m_lflag = 0; m_dflag = 0; m_dprev = 1;
      gen_cnt <= 0;
    end else begin
      bit ld, dn, cacc, kacc;
      logic [CW-1:0] lc;
      ld = m_load();
      dn = m_done();
      cacc = cnt_wr && mq_cnt.size() < 2;
      kacc = ctl_wr && mq_ctl.size() < 2;
      lc = (mq_cnt.size() > 0) ? mq_cnt[0] : '0;
      if (ld && load_det_en) m_lflag = 1;
      else if (load_occ_clr) m_lflag = 0;
      if (dn && !m_dprev && done_det_en) m_dflag = 1;
      else if (done_occ_clr) m_dflag = 0;
      m_dprev = dn;
      if (queue_rst) begin
        mq_cnt.delete(); mq_ctl.delete(); m_last = '0;
      end else begin
        if (ld) begin
          void'(mq_cnt.pop_front());
          if (mq_ctl.size() > 0) m_last = mq_ctl.pop_front();
        end
        if (cacc) mq_cnt.push_back(cnt_wdata);
        if (kacc) mq_ctl.push_back(ctl_wdata);
      end
      if (ld) gen_cnt <= int'(lc);
      else if (gen_cnt > 0 && !gen_hold) gen_cnt <= gen_cnt - 1;
    end
  end

  // compare every cycle away from the active edge
  logic [KW-1:0] seen_ctl[$];
  logic [CW-1:0] seen_cnt[$];
  always @(negedge clk) begin
    if (rst_n) begin
      bit el, ed;
      el = m_load();
      ed = m_done();
      chk("R3 load_stb", 32'(load_stb), 32'(el));
      if (el) begin
        chk("R3 load_count", 32'(load_count), 32'(mq_cnt[0]));
        chk("R4 load_ctl", 32'(load_ctl), 32'((mq_ctl.size() > 0) ? mq_ctl[0] : m_last));
        seen_ctl.push_back(load_ctl);
        seen_cnt.push_back(load_count);
      end
      chk("R2 slots_avail", 32'(slots_avail), 32'(mq_cnt.size() < 2));
      chk("R6 queue_empty", 32'(queue_empty), 32'(mq_cnt.size() == 0));
      chk("R6 data_ready", 32'(data_ready), 32'(mq_cnt.size() != 0));
      chk("R7 move_done", 32'(move_done), 32'(ed));
      chk("R7 chan_idle", 32'(chan_idle), 32'(ed && mq_cnt.size() == 0));
      chk("R8 load_occur", 32'(load_occur), 32'(m_lflag));
      chk("R9 done_occur", 32'(done_occur), 32'(m_dflag));
      chk("R10 load_irq", 32'(load_irq), 32'(m_lflag && load_irq_en));
      chk("R10 done_irq", 32'(done_irq), 32'(m_dflag && done_irq_en));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic put_cnt(input logic [CW-1:0] v);
    cnt_wr = 1; cnt_wdata = v; tick(); cnt_wr = 0;
  endtask
  task automatic put_ctl(input logic [KW-1:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 queue_empty", 32'(queue_empty), 1);
    chk("R1 data_ready", 32'(data_ready), 0);
    chk("R1 slots_avail", 32'(slots_avail), 1);
    chk("R1 move_done", 32'(move_done), 1);
    chk("R1 chan_idle", 32'(chan_idle), 1);
    chk("R1 flags", 32'({load_occur, done_occur, load_irq, done_irq, load_stb}), 0);
    tick();

    // R2 / R5: fill both queues behind a busy generator
    gen_hold = 1;
    put_ctl(28'h111);
    put_cnt(24'd7);
    tick(2);
    put_ctl(28'hA); put_ctl(28'hB); put_ctl(28'hC);
    put_cnt(24'd3); put_cnt(24'd4);
    @(negedge clk);
    chk("R2 slots_avail full", 32'(slots_avail), 0);
    tick();
    put_cnt(24'd5);
    @(negedge clk);
    chk("R2 dropped write keeps full", 32'(slots_avail), 0);
    seen_ctl.delete(); seen_cnt.delete();
    tick();
    gen_hold = 0;
    tick(30);
    chk("R2 load total", 32'(seen_cnt.size()), 2);
    chk("R3 first count", 32'(seen_cnt[0]), 3);
    chk("R3 second count", 32'(seen_cnt[1]), 4);
    chk("R5 first ctl", 32'(seen_ctl[0]), 32'h00A);
    chk("R5 second ctl, third dropped", 32'(seen_ctl[1]), 32'h00B);
    put_cnt(24'd2);
    tick(10);
    chk("R4 reuse last ctl", 32'(seen_ctl[2]), 32'h00B);

    // R8 / R9 / R10: flags, interrupts, clears
    load_det_en = 1; load_irq_en = 1; done_det_en = 1; done_irq_en = 1;
    put_cnt(24'd1);
    tick(6);
    chk("R8 load flag set", 32'(load_occur), 1);
    chk("R10 load irq", 32'(load_irq), 1);
    chk("R9 done flag set", 32'(done_occur), 1);
    load_occ_clr = 1; done_occ_clr = 1; tick(); load_occ_clr = 0; done_occ_clr = 0;
    @(negedge clk);
    chk("R8 load flag clear", 32'(load_occur), 0);
    chk("R9 done flag clear", 32'(done_occur), 0);
    tick();

    // R11: queue reset with entries pending
    gen_hold = 1;
    put_ctl(28'h55);
    put_cnt(24'd9);
    tick(2);
    put_ctl(28'h77); put_cnt(24'd1); put_cnt(24'd1);
    queue_rst = 1; tick(); queue_rst = 0;
    @(negedge clk);
    chk("R11 queue emptied", 32'(queue_empty), 1);
    chk("R11 slots back", 32'(slots_avail), 1);
    chk("R11 load flag kept", 32'(load_occur), 1);
    tick();
    gen_hold = 0;
    tick(15);
    seen_ctl.delete();
    put_cnt(24'd1);
    tick(4);
    chk("R11 remembered ctl cleared", 32'(seen_ctl[0]), 0);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      cnt_wr = ($urandom % 3) == 0;
      cnt_wdata = CW'($urandom % 6);
      ctl_wr = ($urandom % 4) == 0;
      ctl_wdata = KW'($urandom);
      gen_hold = ($urandom % 4) == 0;
      queue_rst = ($urandom % 80) == 0;
      load_occ_clr = ($urandom % 5) == 0;
      done_occ_clr = ($urandom % 5) == 0;
      if (($urandom % 50) == 0) begin
        load_det_en = $urandom; done_det_en = $urandom;
        load_irq_en = $urandom; done_irq_en = $urandom;
      end
      tick();
    end
    cnt_wr = 0; ctl_wr = 0; queue_rst = 0; gen_hold = 0;
    tick(4);
    finish_run();
  end
endmodule